// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request port inside the chip and an external static RAM of 8K bytes that has no clock. A requester offers one access at a time with a valid/ready handshake: a write flag, a 13-bit word address and a byte of write data. The controller then drives the memory's two chip selects (one active low, one active high), its output-enable and write-enable strobes, the address bus and a byte-wide data bus. The data bus is split into a driven value, a drive-enable and a sampled input, so that a pad ring can build the bidirectional pin. Read results come back on a one-cycle `rsp_valid` pulse. The response side has no back-pressure, so the requester must always be able to take a read result.

Every phase length is a whole number of clock cycles. It is worked out at elaboration from a clock period and from nanosecond limits for access, strobe width, data setup and cycle time. Each limit is divided by the period, rounded up, and never taken below one cycle. Back-pressure follows one rule: `req_ready` is high only while the controller is idle and no standby is being requested. The requester must hold `req_valid` and its payload steady until it sees `req_ready` high at a rising edge. A plain `standby_req` input deselects the memory so it can drop to its low-power state. After standby ends, the memory stays selected for a full read-cycle time before the next access can start.

Top module: `sram_async_ctrl`

## Requirements
- R1: While the controller is in standby, and from reset, `ram_sel_n`=1, `ram_sel`=0, `ram_oe_n`=1, `ram_we_n`=1 and `ram_dq_oe`=0. At all other times `ram_sel_n`=0 and `ram_sel`=1.
- R2: A read holds `ram_oe_n` low and `ram_we_n` high with the address unchanged. It samples `ram_dq_in` at the edge that ends the phase. `rsp_valid` is high for exactly one cycle, NR cycles after the accepting edge, and `rsp_rdata` equals the byte last written to that address.
- R3: A write holds `ram_oe_n` high for its whole duration and pulls `ram_we_n` low for exactly NW consecutive cycles, one cycle after the accepting edge.
- R4: `ram_dq_oe` rises only after `ram_we_n` has already been low for a full cycle. It falls only after `ram_we_n` has been high for a full cycle. While it is high, `ram_dq_out` carries the accepted write byte, for at least ceil(tDW/period) cycles before `ram_we_n` rises.
- R5: `ram_addr` changes only at an accepting edge. It never changes at an edge where `ram_we_n` was low.
- R6: `req_ready` is low in reset and for every cycle of an access after the accepting edge. A request is taken only at an edge where both `req_valid` and `req_ready` are high.
- R7: A standby request takes effect only from idle. If it arrives during an access, the memory stays selected until that access ends. If it arrives in the same cycle as `req_valid`, standby wins, `req_ready` stays low, no strobe is issued, and the request is served after standby ends.
- R8: After leaving standby (or reset), the memory is selected for at least NC=ceil(tRC/period) cycles before `req_ready` rises.
- R9: The phase counts are NR=max(ceil(tAA), ceil(tOE), ceil(tRC)) and NW=max(ceil(tWP), ceil(tAW), ceil(tWHZ+tDW), 1+ceil(tDW)), each in cycles and at least one. With the defaults (20 ns clock, 35/25/25/30/20/15 ns), NR=2 and NW=2.
- R10: `ram_oe_n` and `ram_we_n` are never low together, and the controller never drives the bus while `ram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read result |
| standby_req | input | 1 | Deselect the memory for low power |
| ram_addr | output | 13 | Memory address bus |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_dq_out | output | 8 | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The standby request and the request handshake can land in the same idle cycle. The bench provokes this by raising `standby_req` and `req_valid` on the same falling edge. It then judges that `req_ready` stayed low, that both chip selects went to the deselected levels with no strobe, and that the held request was later written and read back correctly after the wake-up wait. A second collision raises standby one cycle into a read. There the memory must stay selected until the read returns its correct byte, and deselect only afterwards. A bus-side model checks the strobe widths, the data-drive window, address stability and the access-time counts on every access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WRECOV,
    PH_SLEEP,
    PH_WAKE
  } phase_e;

  // ceiling of ns/period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD  = 2,
  parameter int N_WP  = 2,
  parameter int N_WR  = 1,
  parameter int N_RC  = 2,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic standby_req,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic sel_n,
  output logic sel,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);
  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_WR = CNT_W'(N_WR - 1);
  localparam logic [CNT_W-1:0] LD_RC = CNT_W'(N_RC - 1);

  phase_e           ph_q, ph_d;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign req_ready = (ph_q == PH_IDLE) && !standby_req;
  assign accept    = req_valid && req_ready;
  assign capture   = (ph_q == PH_READ) && expired;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (standby_req)    ph_d = PH_SLEEP;
        else if (req_valid) ph_d = req_write ? PH_WSETUP : PH_READ;
      end
      PH_READ:   if (expired) ph_d = PH_IDLE;
      PH_WSETUP: ph_d = PH_WPULSE;
      PH_WPULSE: if (expired) ph_d = PH_WRECOV;
      PH_WRECOV: if (expired) ph_d = PH_IDLE;
      PH_SLEEP:  if (!standby_req) ph_d = PH_WAKE;
      PH_WAKE:   if (expired) ph_d = PH_IDLE;
      default:   ph_d = PH_SLEEP;
    endcase
  end

  always_comb begin
    tmr_load = (ph_d != ph_q);
    unique case (ph_d)
      PH_READ:   tmr_val = LD_RD;
      PH_WPULSE: tmr_val = LD_WP;
      PH_WRECOV: tmr_val = LD_WR;
      PH_WAKE:   tmr_val = LD_RC;
      default:   tmr_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  // pins are registered from the next phase so they never glitch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_SLEEP;
      sel_n <= 1'b1;
      sel   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      sel_n <= (ph_d == PH_SLEEP);
      sel   <= (ph_d != PH_SLEEP);
      oe_n  <= (ph_d != PH_READ);
      we_n  <= (ph_d != PH_WPULSE);
      dq_oe <= ((ph_d == PH_WPULSE) && (ph_q == PH_WPULSE)) || (ph_d == PH_WRECOV);
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R1
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!sel && oe_n && we_n && !dq_oe));

  // R4
  drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (!we_n && !$past(we_n)));

  // R4
  release_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (we_n && $past(we_n)));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7
  standby_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> $past(ph_q == PH_IDLE));
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      dq_out   <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 35,
  parameter int T_AA_NS       = 35,
  parameter int T_OE_NS       = 25,
  parameter int T_WC_NS       = 35,
  parameter int T_AW_NS       = 30,
  parameter int T_WP_NS       = 25,
  parameter int T_DW_NS       = 20,
  parameter int T_WHZ_NS      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              standby_req,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned P     = CLK_PERIOD_NS;
  localparam int unsigned N_RD  = umax(umax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_OE_NS, P)),
                                       ns_to_cyc(T_RC_NS, P));
  localparam int unsigned N_WP  = umax(umax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_AW_NS, P)),
                                       umax(ns_to_cyc(T_WHZ_NS + T_DW_NS, P),
                                            1 + ns_to_cyc(T_DW_NS, P)));
  localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, P);
  localparam int unsigned N_WR  = (N_WC > N_WP + 1) ? (N_WC - N_WP - 1) : 1;
  localparam int unsigned N_RC  = ns_to_cyc(T_RC_NS, P);
  localparam int unsigned N_MAX = umax(umax(N_RD, N_WP), umax(N_WR, N_RC));
  localparam int          CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  logic accept, capture;

  sram_ctrl_seq #(
    .N_RD (N_RD), .N_WP (N_WP), .N_WR (N_WR), .N_RC (N_RC), .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .standby_req (standby_req),
    .req_ready   (req_ready),
    .accept      (accept),
    .capture     (capture),
    .sel_n       (ram_sel_n),
    .sel         (ram_sel),
    .oe_n        (ram_oe_n),
    .we_n        (ram_we_n),
    .dq_oe       (ram_dq_oe)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (ram_dq_in),
    .mem_addr  (ram_addr),
    .dq_out    (ram_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ram_we_n) |-> $stable(ram_addr));

  // R5
  addr_move_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr) |-> $past(accept));
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int PER = 20;
  localparam int TRC = 35, TAA = 35, TOE = 25, TWC = 35, TAW = 30, TWP = 25, TDW = 20, TWHZ = 15;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_RD = mx(mx(cdiv(TAA), cdiv(TOE)), cdiv(TRC));
  localparam int C_WP = mx(mx(cdiv(TWP), cdiv(TAW)), mx(cdiv(TWHZ + TDW), 1 + cdiv(TDW)));
  localparam int C_RC = cdiv(TRC);
  localparam int C_DW = cdiv(TDW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  rsp_rdata, ram_dq_out;
  logic [7:0]  ram_dq_in = 8'hE7;
  logic [12:0] ram_addr;

  always #(PER/2) clk = ~clk;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .standby_req(standby_req),
    .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // bench-side memory contents and scoreboard
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  int         lat_q [$];

  // bus-side memory model with timing checks, sampled after the falling edge
  logic [12:0] last_addr = '0, wa_start = '0;
  logic [7:0]  wlatch = '0;
  int oe_cnt = 0, addr_cnt = 0, sel_cnt = 0, we_cnt = 0, drv_cnt = 0;
  bit prev_we = 1, prev_oe = 1, prev_dqoe = 0, was_sb = 1;

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      oe_cnt = 0; addr_cnt = 0; sel_cnt = 0; we_cnt = 0; drv_cnt = 0;
      prev_we = 1; prev_oe = 1; prev_dqoe = 0; was_sb = 1;
    end else begin
      // selection and wake-up window
      if (ram_sel_n || !ram_sel) begin sel_cnt = 0; was_sb = 1; end
      else sel_cnt++;
      if (req_ready && was_sb) begin
        chk(sel_cnt >= C_RC, "R8 wake wait", sel_cnt, C_RC);
        was_sb = 0;
      end
      addr_cnt = (ram_addr != last_addr) ? 1 : addr_cnt + 1;
      last_addr = ram_addr;
      // read side
      oe_cnt = ram_oe_n ? 0 : oe_cnt + 1;
      if (prev_oe == 0 && ram_oe_n) chk(1'b1, "R9", 0, 0);
      if (!ram_oe_n && ram_oe_n !== prev_oe) ; // start of read
      if (prev_oe == 0 && ram_oe_n == 1) ;
      if (!ram_sel_n && !ram_oe_n && ram_we_n && oe_cnt >= cdiv(TOE) && addr_cnt >= cdiv(TAA))
        ram_dq_in = ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)] : 8'h00;
      else
        ram_dq_in = 8'hE7;
      if (ram_dq_oe && !ram_oe_n) chk(1'b0, "R10 bus contention", 1, 0);
      // write side
      if (!ram_we_n) begin
        if (prev_we) wa_start = ram_addr;
        we_cnt++;
        if (!ram_oe_n) chk(1'b0, "R3 oe low in write", 0, 1);
        if (ram_addr != wa_start) chk(1'b0, "R5 addr moved in write", ram_addr, wa_start);
        if (ram_dq_oe) begin drv_cnt++; wlatch = ram_dq_out; end
      end
      if (ram_dq_oe && !prev_dqoe)
        chk(!ram_we_n && we_cnt >= 2, "R4 drive start", we_cnt, 2);
      if (!ram_dq_oe && prev_dqoe)
        chk(ram_we_n && prev_we, "R4 drive release", ram_we_n, 1);
      if (!prev_we && ram_we_n) begin
        chk(we_cnt == C_WP, "R3/R9 write pulse cycles", we_cnt, C_WP);
        chk(drv_cnt >= C_DW, "R4 data setup cycles", drv_cnt, C_DW);
        ram[int'(wa_start)] = wlatch;
        we_cnt = 0; drv_cnt = 0;
      end
      prev_we = ram_we_n; prev_oe = ram_oe_n; prev_dqoe = ram_dq_oe;
      // scoreboard monitor
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", rsp_rdata, 0);
        else begin
          logic [7:0] e;
          int l;
          e = exp_q.pop_front();
          l = lat_q.pop_front();
          chk(rsp_rdata == e, "R2 read data", rsp_rdata, e);
          chk(cyc - l == C_RD, "R2/R9 read latency", cyc - l, C_RD);
        end
      end
    end
  end

  // read phase length measured on oe_n
  int oe_run = 0;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (!ram_oe_n) oe_run++;
      else if (oe_run != 0) begin
        chk(oe_run == C_RD, "R9 read phase cycles", oe_run, C_RD);
        oe_run = 0;
      end
    end
  end

  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      lat_q.push_back(cyc + 1);
    end
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(req_ready == 0, "R6 ready low during access", req_ready, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe, "R1 reset pins",
        {ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe}, 5'b10110);
    chk(req_ready == 0, "R6 ready in reset", req_ready, 0);
    rst_n = 1;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    chk(!ram_sel_n && ram_sel, "R1 selected when awake", ram_sel_n, 0);

    // corner addresses and patterns
    issue(1, 13'h0000, 8'h3C);
    issue(1, 13'h1FFF, 8'hC3);
    issue(1, 13'h0AAA, 8'h55);
    issue(1, 13'h1555, 8'hAA);
    issue(0, 13'h0000, 0);
    issue(0, 13'h1FFF, 0);
    issue(0, 13'h0AAA, 0);
    issue(0, 13'h1555, 0);
    // write then read same address back to back (R5)
    issue(1, 13'h0100, 8'h99);
    issue(0, 13'h0100, 0);
    issue(1, 13'h0000, 8'h00);
    issue(0, 13'h0000, 0);
    for (int i = 0; i < 16; i++) issue(1, 13'((i * 509) & 13'h1FFF), 8'(i * 37 + 1));
    for (int i = 15; i >= 0; i--) issue(0, 13'((i * 509) & 13'h1FFF), 0);
    repeat (6) @(negedge clk);

    // R7: standby and a request in the same idle cycle
    @(negedge clk);
    standby_req = 1; req_valid = 1; req_write = 1; req_addr = 13'h0777; req_wdata = 8'h6E;
    #1;
    chk(req_ready == 0, "R7 standby beats request", req_ready, 0);
    @(negedge clk); #1;
    chk(ram_sel_n && !ram_sel && !ram_dq_oe, "R1/R7 deselected in standby",
        {ram_sel_n, ram_sel}, 2'b10);
    repeat (4) begin
      @(negedge clk); #1;
      chk(ram_we_n && req_ready == 0, "R7 no write while in standby", ram_we_n, 1);
    end
    standby_req = 0;
    @(negedge clk); #1;
    chk(!ram_sel_n && ram_sel && req_ready == 0, "R8 wake select before ready", req_ready, 0);
    while (!req_ready) begin @(negedge clk); #1; end
    shadow[32'h0777] = 8'h6E;
    @(negedge clk);
    req_valid = 0;
    issue(0, 13'h0777, 0);

    // R7: standby raised during a read
    issue(1, 13'h0321, 8'hB4);
    issue(0, 13'h0321, 0);
    standby_req = 1;
    @(negedge clk); #1;
    chk(!ram_sel_n, "R7 stays selected during access", ram_sel_n, 0);
    repeat (4) @(negedge clk);
    #1;
    chk(ram_sel_n && !ram_sel, "R7 standby after access", ram_sel_n, 1);
    standby_req = 0;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    issue(0, 13'h0321, 0);
    issue(0, 13'h1FFF, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule